// File: doc/BRIEF.md
# Register Interlock Scoreboard

This block decides, one instruction at a time, whether an issuing instruction has to wait because one of its source registers will not hold a usable value when the instruction actually reads it. For every architectural register it keeps a small signed timer. A positive value is the number of cycles still to wait before a pending result can be consumed. Zero or a negative value means the register is usable, and a negative value also records how long it has been usable, down to a saturation floor.

Each source operand carries a signed read offset. Zero means the operand is read in the issue cycle. A positive value `o` means it is sampled `o` cycles later, so the remaining wait may be up to `o`. A negative value `-e` means the operand must already have been usable for `e` cycles when the instruction starts.

The destination carries the number of cycles for which its result stays unusable after the producing instruction ends. Typical values are 1 for a word load and 2 for byte, halfword or sign-extending loads. A separate countdown models a shared unit, such as a multiplier, that stays occupied for a given number of cycles after an instruction of its class. A later instruction of the same class waits until that countdown expires.

Top module: `reg_interlock_sb`

## Requirements
- R1: Reset leaves every register ready (all `reg_ready` bits 1) and the shared unit free. The first instruction after reset issues without a stall, whatever its operands are.
- R2: `stall` is 0 in every cycle where `issue_valid` is 0, whatever the other inputs are.
- R3: An accepted instruction in cycle t that writes register d with latency k>0 has these effects. `reg_ready[d]` is 0 in cycles t+1..t+k and 1 in cycle t+1+k. A consumer that reads d at offset 0 stalls in cycles t+1..t+k and is accepted in cycle t+1+k.
- R4: A source operand with a positive offset `o` (3-bit two's complement) does not stall when the remaining wait is at most `o`. It stalls when the remaining wait is larger than `o`.
- R5: A source operand with a negative offset `-e` stalls until the register has been ready for at least `e` cycles. With latency 1 written in cycle t and offset -2, the consumer stalls in cycles t+1..t+3 and is accepted in cycle t+4.
- R6: A write with latency 0 leaves the register usable by the very next instruction.
- R7: A write to register index 15 (the program counter) never makes that register unready and never causes a stall.
- R8: While `stall` is 1, the stalled instruction loads no timer, and its destination stays ready. The same request is evaluated again every cycle and is accepted in the first cycle its hazards are gone.
- R9: An accepted instruction with `res_use`=1 and `res_hold`=k makes every `res_use`=1 instruction in the next k cycles stall. Instructions with `res_use`=0 are not affected.
- R10: A newer accepted write to a register replaces any older pending wait on it, even when the new wait is shorter.
- R11: A source operand whose valid bit is 0 never causes a stall.
- R12: Both source operands are checked in the same cycle, and a hazard on either one stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented for issue |
| src0_valid | input | 1 | Source operand 0 is used |
| src0_idx | input | 4 | Register index of source operand 0 |
| src0_ofs | input | 3 | Signed read offset of operand 0 (negative = needed early) |
| src1_valid | input | 1 | Source operand 1 is used |
| src1_idx | input | 4 | Register index of source operand 1 |
| src1_ofs | input | 3 | Signed read offset of operand 1 |
| dst_valid | input | 1 | The instruction writes a register |
| dst_idx | input | 4 | Destination register index |
| dst_lat | input | 3 | Cycles the result stays unusable after the instruction |
| res_use | input | 1 | The instruction belongs to the shared-unit class |
| res_hold | input | 2 | Cycles the shared unit stays busy afterwards |
| stall | output | 1 | The presented instruction must wait this cycle |
| reg_ready | output | 16 | Per-register ready flags, bit i for register i |

## Verification
A register timer that holds a wrong value shows at the ports in the next cycle in two ways: its `reg_ready` bit has the wrong value, and a consumer reading that register at the boundary offset gets the wrong `stall` decision. The bench therefore compares both outputs in every cycle of each scenario. If the timer decrements wrongly or saturates at the wrong point, the error only shows at the exact cycle where a late or early operand crosses its threshold. Every such crossing is probed one cycle before, at and after the boundary. A wrong shared-unit count shows as a one-cycle shift in the stall of a same-class instruction.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int SB_NUM_REGS_DEF = 16;
   localparam int SB_CNT_W_DEF    = 4;
   localparam int SB_LAT_W_DEF    = 3;
   localparam int SB_OFS_W_DEF    = 3;
   localparam int SB_RES_W_DEF    = 2;
   localparam int SB_PC_IDX_DEF   = 15;

   typedef enum logic [1:0] {
      SB_PC_TRACKED  = 2'd0,
      SB_PC_EXCLUDED = 2'd1
   } sb_pc_mode_e;
endpackage

// File: rtl/sb_reg_timer.sv
module sb_reg_timer #(
   parameter int CNT_W = sb_pkg::SB_CNT_W_DEF,
   parameter int LAT_W = sb_pkg::SB_LAT_W_DEF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [LAT_W-1:0]        lat,
   output logic signed [CNT_W-1:0] cnt,
   output logic                    ready
);
   localparam logic signed [CNT_W-1:0] FLOOR = {1'b1, {(CNT_W-1){1'b0}}};

   if (LAT_W >= CNT_W) begin : g_bad_width
      $error("sb_reg_timer: LAT_W must be below CNT_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= FLOOR;
      else if (load)     cnt <= {{(CNT_W-LAT_W){1'b0}}, lat};
      else if (cnt != FLOOR) cnt <= cnt - 1'b1;
   end

   assign ready = cnt[CNT_W-1] || (cnt == '0);

   assert_countdown_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !cnt[CNT_W-1] && cnt != '0) |=> (cnt == $past(cnt - 1'b1)));
endmodule

// File: rtl/sb_operand_check.sv
module sb_operand_check #(
   parameter int NUM_REGS = sb_pkg::SB_NUM_REGS_DEF,
   parameter int CNT_W    = sb_pkg::SB_CNT_W_DEF,
   parameter int OFS_W    = sb_pkg::SB_OFS_W_DEF,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      valid,
   input  logic [IDX_W-1:0]          idx,
   input  logic [OFS_W-1:0]          ofs,
   input  logic [NUM_REGS*CNT_W-1:0] cnt_flat,
   output logic                      hazard
);
   if (OFS_W >= CNT_W) begin : g_bad_width
      $error("sb_operand_check: OFS_W must be below CNT_W");
   end

   logic signed [CNT_W-1:0] sel_cnt;
   logic signed [CNT_W-1:0] ofs_ext;

   assign sel_cnt = cnt_flat[idx*CNT_W +: CNT_W];
   assign ofs_ext = {{(CNT_W-OFS_W){ofs[OFS_W-1]}}, ofs};
   assign hazard  = valid && (sel_cnt > ofs_ext);

   assert_unused_operand_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !hazard);
endmodule

// File: rtl/sb_busy_timer.sv
module sb_busy_timer #(
   parameter int RES_W = sb_pkg::SB_RES_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RES_W-1:0] hold,
   output logic             busy
);
   logic [RES_W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)          left <= '0;
      else if (load)       left <= hold;
      else if (left != '0) left <= left - 1'b1;
   end

   assign busy = (left != '0);

   assert_busy_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> (left == $past(left - 1'b1)));
endmodule

// File: rtl/reg_interlock_sb.sv
module reg_interlock_sb #(
   parameter int  NUM_REGS = sb_pkg::SB_NUM_REGS_DEF,
   parameter int  CNT_W    = sb_pkg::SB_CNT_W_DEF,
   parameter int  LAT_W    = sb_pkg::SB_LAT_W_DEF,
   parameter int  OFS_W    = sb_pkg::SB_OFS_W_DEF,
   parameter int  RES_W    = sb_pkg::SB_RES_W_DEF,
   parameter int  PC_IDX   = sb_pkg::SB_PC_IDX_DEF,
   parameter sb_pkg::sb_pc_mode_e PC_MODE = sb_pkg::SB_PC_EXCLUDED,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue_valid,
   input  logic                src0_valid,
   input  logic [IDX_W-1:0]    src0_idx,
   input  logic [OFS_W-1:0]    src0_ofs,
   input  logic                src1_valid,
   input  logic [IDX_W-1:0]    src1_idx,
   input  logic [OFS_W-1:0]    src1_ofs,
   input  logic                dst_valid,
   input  logic [IDX_W-1:0]    dst_idx,
   input  logic [LAT_W-1:0]    dst_lat,
   input  logic                res_use,
   input  logic [RES_W-1:0]    res_hold,
   output logic                stall,
   output logic [NUM_REGS-1:0] reg_ready
);
   localparam int NUM_SRC = 2;

   if (NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("reg_interlock_sb: NUM_REGS must be a power of two");
   end
   if (PC_IDX >= NUM_REGS) begin : g_bad_pc
      $error("reg_interlock_sb: PC_IDX out of range");
   end

   logic [NUM_REGS*CNT_W-1:0] cnt_flat;
   logic [NUM_SRC-1:0]        src_v;
   logic [IDX_W-1:0]          src_i [NUM_SRC];
   logic [OFS_W-1:0]          src_o [NUM_SRC];
   logic [NUM_SRC-1:0]        hz;
   logic                      busy;
   logic                      accept;

   assign src_v    = {src1_valid, src0_valid};
   assign src_i[0] = src0_idx;
   assign src_i[1] = src1_idx;
   assign src_o[0] = src0_ofs;
   assign src_o[1] = src1_ofs;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      sb_operand_check #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
         .clk(clk), .rst_n(rst_n), .valid(src_v[s]), .idx(src_i[s]),
         .ofs(src_o[s]), .cnt_flat(cnt_flat), .hazard(hz[s]));
   end

   sb_busy_timer #(.RES_W(RES_W)) u_busy (
      .clk(clk), .rst_n(rst_n), .load(accept && res_use),
      .hold(res_hold), .busy(busy));

   assign stall  = issue_valid && ((|hz) || (res_use && busy));
   assign accept = issue_valid && !stall;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic load_r;
      if (PC_MODE == sb_pkg::SB_PC_EXCLUDED && r == PC_IDX) begin : g_pc
         assign load_r = 1'b0;
      end else begin : g_gpr
         assign load_r = accept && dst_valid && (dst_idx == IDX_W'(r));
      end

      sb_reg_timer #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_tmr (
         .clk(clk), .rst_n(rst_n), .load(load_r), .lat(dst_lat),
         .cnt(cnt_flat[r*CNT_W +: CNT_W]), .ready(reg_ready[r]));

      assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(reg_ready[r]) |->
            $past(issue_valid && !stall && dst_valid && dst_idx == IDX_W'(r) && dst_lat != '0));
      assert_no_load_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (stall && reg_ready[r]) |=> reg_ready[r]);
   end

   assert_idle_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> !stall);
   assert_shared_unit_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && res_use && busy) |-> stall);
   if (PC_MODE == sb_pkg::SB_PC_EXCLUDED) begin : g_pc_chk
      assert_pc_always_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
         reg_ready[PC_IDX]);
   end
endmodule

// File: tb/reg_interlock_sb_bench.sv
`timescale 1ns/1ps
module reg_interlock_sb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic        src0_valid = 1'b0, src1_valid = 1'b0, dst_valid = 1'b0, res_use = 1'b0;
   logic [3:0]  src0_idx = '0, src1_idx = '0, dst_idx = '0;
   logic [2:0]  src0_ofs = '0, src1_ofs = '0, dst_lat = '0;
   logic [1:0]  res_hold = '0;
   logic        stall;
   logic [15:0] reg_ready;

   typedef struct {
      logic        e_stall;
      logic [15:0] e_rdy;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   reg_interlock_sb u_reg_interlock_sb (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
      .src0_valid(src0_valid), .src0_idx(src0_idx), .src0_ofs(src0_ofs),
      .src1_valid(src1_valid), .src1_idx(src1_idx), .src1_ofs(src1_ofs),
      .dst_valid(dst_valid), .dst_idx(dst_idx), .dst_lat(dst_lat),
      .res_use(res_use), .res_hold(res_hold),
      .stall(stall), .reg_ready(reg_ready));

   task automatic step(input bit iv, input bit av, input int ai, input int ao,
                       input bit bv, input int bi, input int bo,
                       input bit dv, input int di, input int dl,
                       input bit ru, input int rh,
                       input bit es, input logic [15:0] er, input string tag);
      exp_t it;
      @(negedge clk);
      issue_valid = iv;
      src0_valid = av; src0_idx = 4'(ai); src0_ofs = 3'(ao);
      src1_valid = bv; src1_idx = 4'(bi); src1_ofs = 3'(bo);
      dst_valid = dv;  dst_idx = 4'(di);  dst_lat = 3'(dl);
      res_use = ru;    res_hold = 2'(rh);
      it.e_stall = es; it.e_rdy = er; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic idle(input logic [15:0] er, input string tag);
      step(0, 0,0,0, 0,0,0, 0,0,0, 0,0, 1'b0, er, tag);
   endtask
   task automatic use_reg(input int i, input int o, input bit es, input logic [15:0] er, input string tag);
      step(1, 1,i,o, 0,0,0, 0,0,0, 0,0, es, er, tag);
   endtask
   task automatic wr(input int d, input int l, input logic [15:0] er, input string tag);
      step(1, 0,0,0, 0,0,0, 1,d,l, 0,0, 1'b0, er, tag);
   endtask
   task automatic res(input bit ru, input int rh, input bit es, input string tag);
      step(1, 0,0,0, 0,0,0, 0,0,0, ru,rh, es, 16'hFFFF, tag);
   endtask

   // monitor: pops one expectation per cycle, between the drive point and the next edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            total++;
            if (stall !== it.e_stall) begin
               bad++;
               $display("FAIL %s stall act=%0b exp=%0b", it.tag, stall, it.e_stall);
            end
            total++;
            if (reg_ready !== it.e_rdy) begin
               bad++;
               $display("FAIL %s reg_ready act=%h exp=%h", it.tag, reg_ready, it.e_rdy);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle(16'hFFFF, "R1 reset state");
      use_reg(3, 0, 0, 16'hFFFF, "R1 no stall after reset");
      // R3 latency 2
      wr(3, 2, 16'hFFFF, "R3 producer");
      use_reg(3, 0, 1, 16'hFFF7, "R3 wait 2");
      use_reg(3, 0, 1, 16'hFFF7, "R3 wait 1");
      use_reg(3, 0, 0, 16'hFFFF, "R8 re-evaluated and accepted");
      // R6
      wr(4, 0, 16'hFFFF, "R6 zero latency write");
      use_reg(4, 0, 0, 16'hFFFF, "R6 immediate use");
      // R7
      wr(15, 3, 16'hFFFF, "R7 pc write");
      use_reg(15, 0, 0, 16'hFFFF, "R7 pc use");
      // R4 late read
      wr(5, 3, 16'hFFFF, "R4 producer");
      use_reg(5, 2, 1, 16'hFFDF, "R4 wait 3 > ofs 2");
      use_reg(5, 2, 0, 16'hFFDF, "R4 wait 2 <= ofs 2");
      idle(16'hFFDF, "R4 drain");
      idle(16'hFFFF, "R4 drained");
      // R5 early read
      wr(6, 1, 16'hFFFF, "R5 producer");
      use_reg(6, -2, 1, 16'hFFBF, "R5 pending");
      use_reg(6, -2, 1, 16'hFFFF, "R5 ready 0 cycles");
      use_reg(6, -2, 1, 16'hFFFF, "R5 ready 1 cycle");
      use_reg(6, -2, 0, 16'hFFFF, "R5 ready 2 cycles");
      // R11
      wr(7, 2, 16'hFFFF, "R11 producer");
      step(1, 0,7,0, 0,0,0, 0,0,0, 0,0, 1'b0, 16'hFF7F, "R11 invalid operand");
      idle(16'hFF7F, "R11 drain");
      idle(16'hFFFF, "R11 drained");
      // R12
      wr(8, 1, 16'hFFFF, "R12 producer");
      step(1, 1,2,0, 1,8,0, 0,0,0, 0,0, 1'b1, 16'hFEFF, "R12 hazard on operand 1");
      step(1, 1,2,0, 1,8,0, 0,0,0, 0,0, 1'b0, 16'hFFFF, "R12 both clear");
      // R10
      wr(9, 4, 16'hFFFF, "R10 long producer");
      wr(9, 1, 16'hFDFF, "R10 short overwrite");
      use_reg(9, 0, 1, 16'hFDFF, "R10 wait 1");
      use_reg(9, 0, 0, 16'hFFFF, "R10 newer latency wins");
      // R8 no load while stalled
      wr(10, 2, 16'hFFFF, "R8 producer");
      step(1, 1,10,0, 0,0,0, 1,11,3, 0,0, 1'b1, 16'hFBFF, "R8 stalled writer");
      idle(16'hFBFF, "R8 dst 11 untouched");
      idle(16'hFFFF, "R8 drained");
      // R9 shared unit
      res(1, 1, 0, "R9 first user");
      res(1, 2, 1, "R9 blocked 1 cycle");
      res(1, 2, 0, "R9 second user");
      res(0, 0, 0, "R9 other class free");
      res(1, 0, 1, "R9 still busy");
      res(1, 0, 0, "R9 third user hold 0");
      res(1, 0, 0, "R9 no hold");
      // R2
      wr(12, 3, 16'hFFFF, "R2 producer");
      step(0, 1,12,0, 0,0,0, 0,0,0, 1,0, 1'b0, 16'hEFFF, "R2 no issue no stall");
      idle(16'hEFFF, "R2 drain");
      idle(16'hEFFF, "R2 drain");
      idle(16'hFFFF, "R2 drained");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule